// File: doc/BRIEF.md
# Serial Clock Prescaler

This block turns the system clock into the serial clock of a synchronous serial master, together with a pair of one-cycle strobes that tell the shift engine when the serial clock leaves its idle level and when it returns to it. The shift engine uses the leading strobe and the trailing strobe to decide when to launch and when to capture data. Chip-select timing and the data path are handled elsewhere.

The settings come from the chip select that is currently active. A 4-bit modulus sets the base rate. An optional slow-down stage divides the rate by a further 16. A polarity bit chooses whether the serial clock rests high or low. The divider runs only while `run` is high. When `run` is low, every counter is held cleared and the serial clock sits at its rest level. Each new run therefore starts from the same phase.

One full serial clock period is 4 × (modulus + 1) system cycles, and 16 times that when the slow stage is enabled. The fastest setting divides the system clock by 4 and the slowest divides it by 1024. The duty cycle is exactly 50%.

Top module: `sck_prescaler`

## Requirements
- R1: While reset is held, and in the first cycle after it, `sclk` equals `idle_high` and both `lead_stb` and `trail_stb` are 0.
- R2: While `run` is low, `sclk` stays at the `idle_high` level for both polarities, and neither strobe pulses.
- R3: With `slow_en`=0, the half period is H = 2 × (`modulus`+1) system cycles. After `run` rises, `sclk` first leaves its idle level on the H-th rising clock edge at which `run` is high. It then changes every H edges.
- R4: With `slow_en`=1, the half period is H = 32 × (`modulus`+1) system cycles, with the same first-edge rule as R3.
- R5: The fastest setting (`modulus`=0, `slow_en`=0) gives a serial clock period of 4 system cycles, 2 high and 2 low.
- R6: The slowest setting (`modulus`=15, `slow_en`=1) gives a half period of 512 system cycles.
- R7: `lead_stb` is high for exactly one cycle: the cycle in which `sclk` has just moved away from its idle level. `trail_stb` is high for exactly one cycle: the cycle in which `sclk` has just returned to idle. The two strobes are never high together. While `run` stays high, `sclk` never changes without one of them.
- R8: If `run` falls while `sclk` is away from idle, `sclk` is back at idle in the next cycle and no strobe is issued. A later rise of `run` again produces the first edge after a full H cycles.
- R9: With `idle_high`=1, `sclk` rests high and the waveform is inverted. The strobe timing is the same as with `idle_high`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Divider enable; high while a transaction is active |
| modulus | input | 4 | Prescale modulus; the half period is 2 × (modulus+1) base ticks |
| slow_en | input | 1 | Enables the extra divide-by-16 stage |
| idle_high | input | 1 | Serial clock rest level: 1 means high, 0 means low |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle pulse when sclk leaves its rest level |
| trail_stb | output | 1 | One-cycle pulse when sclk returns to its rest level |

## Verification
The hardest case to reach from the ports is stopping the divider while the serial clock is away from its rest level, and then checking that no stale count is left behind. The stimulus waits for the first leading strobe, lets two more cycles pass inside the active half period, and drops `run`. It then checks that the clock is back at rest with no strobe. Finally it raises `run` again and counts the full H cycles to the next leading edge. The slowest setting is reached by timing a complete 512-cycle half period with the slow stage on.

// File: rtl/sck_pkg.sv
package sck_pkg;

    localparam int SCK_MOD_W   = 4;
    localparam int SCK_PRE_DIV = 16;

    typedef struct packed {
        logic lead;
        logic trail;
    } sck_edge_t;

    // Count value at which a half period ends: 2*(m+1)-1 == {m,1}
    function automatic logic [SCK_MOD_W:0] half_terminal(input logic [SCK_MOD_W-1:0] m);
        return {m, 1'b1};
    endfunction

endpackage

// File: rtl/sck_base_tick.sv
module sck_base_tick #(
    parameter int PRE_DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic slow_en,
    output logic tick
);
    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

    generate
        if (PRE_DIV > 1) begin : g_pre
            logic [PRE_W-1:0] pre_cnt;
            logic             pre_wrap;

            assign pre_wrap = (pre_cnt == PRE_W'(PRE_DIV - 1));

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    pre_cnt <= '0;
                end else if (pre_wrap) begin
                    pre_cnt <= '0;
                end else begin
                    pre_cnt <= pre_cnt + 1'b1;
                end
            end

            assign tick = run && (!slow_en || pre_wrap);
        end else begin : g_nopre
            assign tick = run;
        end
    endgenerate

endmodule

// File: rtl/sck_half_counter.sv
module sck_half_counter
    import sck_pkg::*;
#(
    parameter int MOD_W = SCK_MOD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [MOD_W-1:0] modulus,
    output logic             toggle
);
    localparam int CNT_W = MOD_W + 1;

    logic [CNT_W-1:0] half_cnt;
    logic [CNT_W-1:0] term;
    logic             at_end;

    assign term   = {modulus, 1'b1};
    assign at_end = (half_cnt >= term);
    assign toggle = run && tick && at_end;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            half_cnt <= '0;
        end else if (tick) begin
            if (at_end) begin
                half_cnt <= '0;
            end else begin
                half_cnt <= half_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sck_phase_gen.sv
module sck_phase_gen
    import sck_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      toggle,
    input  logic      idle_high,
    output logic      sclk,
    output sck_edge_t edges
);
    logic      active_q;
    sck_edge_t edge_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            active_q <= 1'b0;
            edge_q   <= '0;
        end else begin
            edge_q.lead  <= toggle && !active_q;
            edge_q.trail <= toggle && active_q;
            if (toggle) begin
                active_q <= !active_q;
            end
        end
    end

    assign sclk  = idle_high ^ active_q;
    assign edges = edge_q;

endmodule

// File: rtl/sck_prescaler.sv
module sck_prescaler
    import sck_pkg::*;
#(
    parameter int MOD_W   = SCK_MOD_W,
    parameter int PRE_DIV = SCK_PRE_DIV
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [MOD_W-1:0] modulus,
    input  logic             slow_en,
    input  logic             idle_high,
    output logic             sclk,
    output logic             lead_stb,
    output logic             trail_stb
);
    logic      base_tick;
    logic      half_toggle;
    sck_edge_t edges;

    sck_base_tick #(.PRE_DIV(PRE_DIV)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .slow_en (slow_en),
        .tick    (base_tick)
    );

    sck_half_counter #(.MOD_W(MOD_W)) u_half (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .tick    (base_tick),
        .modulus (modulus),
        .toggle  (half_toggle)
    );

    sck_phase_gen u_phase (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .toggle    (half_toggle),
        .idle_high (idle_high),
        .sclk      (sclk),
        .edges     (edges)
    );

    assign lead_stb  = edges.lead;
    assign trail_stb = edges.trail;

endmodule

// File: rtl/sck_prescaler_chk.sv
module sck_prescaler_chk (
    input logic clk,
    input logic rst,
    input logic run,
    input logic idle_high,
    input logic sclk,
    input logic lead_stb,
    input logic trail_stb
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(lead_stb && trail_stb)); // R7

    AST_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(run) |-> (sclk == idle_high)); // R2

    AST_NO_STB_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(run) |-> (!lead_stb && !trail_stb)); // R8

    AST_LEAD_AWAY: assert property (@(posedge clk) disable iff (rst)
        lead_stb |-> (sclk != idle_high)); // R7

    AST_TRAIL_HOME: assert property (@(posedge clk) disable iff (rst)
        trail_stb |-> (sclk == idle_high)); // R7

    AST_LEAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        lead_stb |=> !lead_stb); // R7

    AST_MOVE_HAS_STB: assert property (@(posedge clk) disable iff (rst || !armed)
        (run && $past(run) && $stable(idle_high) && !$stable(sclk)) |-> (lead_stb || trail_stb)); // R7

endmodule

bind sck_prescaler sck_prescaler_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .idle_high (idle_high),
    .sclk      (sclk),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb)
);

// File: tb/sim_sck_prescaler.sv
module sim_sck_prescaler;
    localparam time CLK_PERIOD = 10ns;
    localparam int  LIMIT      = 5000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic [3:0] modulus = 4'd0;
    logic       slow_en = 1'b0;
    logic       idle_high = 1'b0;
    logic       sclk, lead_stb, trail_stb;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sck_prescaler u0 (
        .clk(clk), .rst(rst), .run(run), .modulus(modulus),
        .slow_en(slow_en), .idle_high(idle_high),
        .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R1
    task automatic t_reset();
        rst = 1'b1; run = 1'b0; idle_high = 1'b1;
        repeat (3) @(negedge clk);
        chk(sclk == 1'b1, "R1 sclk in reset", sclk, 1);
        chk(!lead_stb && !trail_stb, "R1 strobes in reset", {lead_stb, trail_stb}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(sclk == 1'b1 && !lead_stb && !trail_stb, "R1 after reset", {sclk, lead_stb, trail_stb}, 4);
    endtask

    // R2: idle level held with run low, both polarities
    task automatic t_idle(input bit c);
        int bad = 0;
        @(negedge clk); run = 1'b0; idle_high = c; modulus = 4'd0; slow_en = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sclk != c || lead_stb || trail_stb) bad++;
        end
        chk(bad == 0, "R2 idle while stopped", bad, 0);
    endtask

    // R3/R4/R5/R6/R7/R9: time one full period from run rising
    task automatic t_rate(input logic [3:0] p, input bit s, input bit c, input string tag);
        int h = 2 * (int'(p) + 1) * (s ? 16 : 1);
        int n;
        @(negedge clk); run = 1'b0; modulus = p; slow_en = s; idle_high = c;
        @(negedge clk); run = 1'b1; n = 0;
        do begin @(negedge clk); n++; end while (sclk == c && n < LIMIT);
        chk(n == h, {tag, " first edge"}, n, h);
        chk(lead_stb && !trail_stb, "R7 lead strobe on leave", {lead_stb, trail_stb}, 2);
        n = 0;
        do begin
            @(negedge clk); n++;
            if (n == 1) chk(!lead_stb, "R7 lead single cycle", lead_stb, 0);
        end while (sclk != c && n < LIMIT);
        chk(n == h, {tag, " active half"}, n, h);
        chk(trail_stb && !lead_stb, "R7 trail strobe on return", {lead_stb, trail_stb}, 1);
        n = 0;
        do begin @(negedge clk); n++; end while (sclk == c && n < LIMIT);
        chk(n == h, {tag, " idle half"}, n, h);
        run = 1'b0;
        @(negedge clk);
        chk(sclk == c, "R2 idle after stop", sclk, c);
    endtask

    // R8: stop while sclk is active, then restart
    task automatic t_stop_mid(input bit c);
        int n;
        @(negedge clk); run = 1'b0; modulus = 4'd3; slow_en = 1'b0; idle_high = c;
        @(negedge clk); run = 1'b1; n = 0;
        do begin @(negedge clk); n++; end while (sclk == c && n < LIMIT);
        repeat (2) @(negedge clk);
        chk(sclk != c, "R8 still active before stop", sclk, !c);
        run = 1'b0;
        @(negedge clk);
        chk(sclk == c, "R8 idle right after stop", sclk, c);
        chk(!lead_stb && !trail_stb, "R8 no strobe on stop", {lead_stb, trail_stb}, 0);
        @(negedge clk); run = 1'b1; n = 0;
        do begin @(negedge clk); n++; end while (sclk == c && n < LIMIT);
        chk(n == 8, "R8 restart full half period", n, 8);
        run = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_idle(1'b0);
        t_idle(1'b1);
        t_rate(4'd0,  1'b0, 1'b0, "R5 fastest");
        t_rate(4'd2,  1'b0, 1'b0, "R3 modulus 2");
        t_rate(4'd15, 1'b0, 1'b0, "R3 modulus 15");
        t_rate(4'd5,  1'b0, 1'b1, "R9 inverted");
        t_rate(4'd1,  1'b1, 1'b0, "R4 slow stage");
        t_rate(4'd15, 1'b1, 1'b1, "R6 slowest");
        t_stop_mid(1'b0);
        t_stop_mid(1'b1);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule